// File: doc/BRIEF.md
# Normally Not-Ready Wait Generator

This block drives the READY input of a processor bus that rests in the not-ready state. Each bus cycle begins with a one-clock start strobe. The strobe empties the block's delay stages and pulls READY low. Four active-low chip selects are then decoded into two request lines, A and B. A fixed mask decides which line each select feeds. Each request line runs through its own shift chain, which advances on every rising clock edge. Each chain is tapped at its own parameterised depth, so one group of devices can receive a short wait and the other a long one.

READY rises when either tap goes high. It then stays high until the next start strobe. A cycle in which no select is asserted never produces READY, and the bus stalls until the next strobe or a reset. A path tapped at depth 0 gives one wait state. Each added stage of depth gives one more.

Top module: `nnr_wait_gen`

## Requirements
- R1: A start strobe sampled on a rising edge forces `ready` low in the following cycle, whatever its earlier state and whatever the selects are doing.
- R2: Select `cs_n[i]` low asserts request A when `CS_MAP[i]` is 0 and request B when `CS_MAP[i]` is 1. Several low selects combine by OR. The default map is 4'b1100: selects 0 and 1 feed A, and selects 2 and 3 feed B.
- R3: With only A-mapped selects held low from the strobe cycle onward, `ready` stays low for exactly `DEPTH_A`+1 cycles after the strobe edge, then goes high.
- R4: With only B-mapped selects held low from the strobe cycle onward, `ready` stays low for exactly `DEPTH_B`+1 cycles after the strobe edge, then goes high.
- R5: Once `ready` is high, it stays high when the selects are released, until the next start strobe.
- R6: When no select is asserted after a strobe, `ready` stays low for as long as that lasts.
- R7: When both paths are requested, `ready` rises as soon as the shorter path delivers, and never goes high without a tap output.
- R8: A synchronous low `rst_n` clears every stage and the hold state. `ready` is low after the reset edge, and no request that was in flight before reset can raise it afterwards.
- R9: A select sampled on the same edge as the start strobe is discarded. A select asserted only during the strobe cycle never raises `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cs_n | input | NUM_CS | Active-low chip selects |
| ready | output | 1 | Bus READY, high means the cycle may complete |

## Verification
A table of select patterns is applied. The patterns are: single A-mapped selects, single B-mapped selects, pairs inside one group, pairs that span both groups, and no select at all. The bench counts the cycles in which `ready` stays low after each strobe. Single patterns separate the two tap depths and confirm the mask routes each select to the right path. Mixed patterns show that the shorter path wins. The empty pattern shows the stall. Directed runs then cover the hold after the selects are released, the clear on a new strobe, a select that is present only on the strobe edge, and a reset that lands while a request is in flight.

// File: rtl/nnr_pkg.sv
// Shared definitions for the normally not-ready wait generator.
// Assumes nothing beyond a single clock domain.
package nnr_pkg;
    // Which delay path a chip select is routed onto.
    typedef enum logic {
        PATH_A = 1'b0,
        PATH_B = 1'b1
    } path_e;
endpackage

// File: rtl/nnr_select_map.sv
// Decodes active-low chip selects into the two request lines.
// Assumes CS_MAP bit i = 0 routes select i to path A and 1 routes it to path B.
module nnr_select_map
    import nnr_pkg::*;
#(
    parameter int               NUM_CS = 4,
    parameter logic [NUM_CS-1:0] CS_MAP = 4'b1100
) (
    input  logic [NUM_CS-1:0] cs_n,
    output logic              req_a,
    output logic              req_b
);
    logic [NUM_CS-1:0] hit_a;
    logic [NUM_CS-1:0] hit_b;

    // One decode slice per select: active when low and routed to that path.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        assign hit_a[i] = ~cs_n[i] & (path_e'(CS_MAP[i]) == PATH_A);
        assign hit_b[i] = ~cs_n[i] & (path_e'(CS_MAP[i]) == PATH_B);
    end

    // Any routed select raises its request.
    always_comb begin
        req_a = |hit_a;
        req_b = |hit_b;
    end
endmodule

// File: rtl/nnr_delay_line.sv
// Shift chain for one request path, tapped DEPTH stages after the first register.
// Assumes clr is the cycle-start strobe and takes priority over shifting.
module nnr_delay_line #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req,
    output logic tap
);
    localparam int STAGES = DEPTH + 1;

    logic [STAGES-1:0] stg;

    // Clear on reset or cycle start, otherwise advance one stage per edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stg <= '0;
        end else begin
            stg[0] <= req;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    // Output taken at the configured depth.
    assign tap = stg[STAGES-1];

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stg == '0)) else $error("stages not cleared"); // R1

    AST_HEAD_SAMPLES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (stg[0] == $past(req))) else $error("head stage mismatch"); // R3
endmodule

// File: rtl/nnr_ready_hold.sv
// Combines the two taps into READY and holds READY high until the next strobe.
// Assumes taps come from chains cleared by the same strobe.
module nnr_ready_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tap_a,
    input  logic tap_b,
    output logic ready
);
    logic held;

    // READY is the held state or either live tap.
    assign ready = held | tap_a | tap_b;

    // Capture READY so it persists; a strobe or reset drops it.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            held <= 1'b0;
        end else begin
            held <= ready;
        end
    end

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready) else $error("ready dropped"); // R5

    AST_RISE_FROM_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (tap_a || tap_b)) else $error("ready rose without tap"); // R7
endmodule

// File: rtl/nnr_wait_gen.sv
// Normally not-ready wait generator: selects -> two delay paths -> READY.
// Assumes DEPTH_A and DEPTH_B lie in 0..7 and cyc_start is a one-clock strobe.
module nnr_wait_gen #(
    parameter int               NUM_CS  = 4,
    parameter logic [NUM_CS-1:0] CS_MAP  = 4'b1100,
    parameter int               DEPTH_A = 1,
    parameter int               DEPTH_B = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [NUM_CS-1:0] cs_n,
    output logic              ready
);
    logic req_a;
    logic req_b;
    logic tap_a;
    logic tap_b;
    logic sel_seen;

    nnr_select_map #(.NUM_CS(NUM_CS), .CS_MAP(CS_MAP)) u_map (
        .cs_n  (cs_n),
        .req_a (req_a),
        .req_b (req_b)
    );

    nnr_delay_line #(.DEPTH(DEPTH_A)) u_line_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cyc_start),
        .req   (req_a),
        .tap   (tap_a)
    );

    nnr_delay_line #(.DEPTH(DEPTH_B)) u_line_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cyc_start),
        .req   (req_b),
        .tap   (tap_b)
    );

    nnr_ready_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .tap_a (tap_a),
        .tap_b (tap_b),
        .ready (ready)
    );

    // Notes whether any request was sampled since the last strobe (checking only).
    always_ff @(posedge clk) begin
        if (!rst_n || cyc_start) begin
            sel_seen <= 1'b0;
        end else if (req_a || req_b) begin
            sel_seen <= 1'b1;
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !ready) else $error("ready high after strobe"); // R1

    AST_NO_SELECT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> sel_seen) else $error("ready without any select"); // R6
endmodule

// File: tb/nnr_wait_gen_test.sv
module nnr_wait_gen_test;
    localparam int         CLK_PERIOD = 10;
    localparam int         DA         = 1;
    localparam int         DB         = 3;
    localparam logic [3:0] MAP        = 4'b1100;
    localparam int         NEVER      = 15;
    localparam int         NVEC       = 8;

    // Vector: {cs_n pattern, class}; class 0 = A only, 1 = B only, 2 = both, 3 = none
    localparam logic [5:0] VEC [NVEC] = '{
        {4'b1110, 2'd0}, {4'b1101, 2'd0}, {4'b1011, 2'd1}, {4'b0111, 2'd1},
        {4'b0110, 2'd2}, {4'b1111, 2'd3}, {4'b1010, 2'd2}, {4'b0011, 2'd1}
    };
    string vtag [NVEC] = '{"R3", "R3", "R4", "R4", "R7", "R6", "R7", "R2"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [3:0] cs_n = 4'b1111;
    logic       ready;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    nnr_wait_gen #(.NUM_CS(4), .CS_MAP(MAP), .DEPTH_A(DA), .DEPTH_B(DB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cs_n      (cs_n),
        .ready     (ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe with a pattern held from the strobe cycle; count low cycles.
    task automatic measure(input logic [3:0] pat, output int cnt);
        cs_n = pat;
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
        cnt = 0;
        for (int k = 0; k < NEVER; k++) begin
            if (ready) break;
            cnt++;
            tick();
        end
    endtask

    function automatic int expect_wait(input logic [1:0] cls);
        case (cls)
            2'd0:    return DA + 1;
            2'd1:    return DB + 1;
            2'd2:    return ((DA < DB) ? DA : DB) + 1;
            default: return NEVER;
        endcase
    endfunction

    initial begin
        int cnt;
        @(negedge clk);
        tick();
        check("R8", int'(ready), 0);          // R8: reset state
        rst_n = 1'b1;
        tick();

        // Table walk: R2 R3 R4 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            measure(VEC[v][5:2], cnt);
            check(vtag[v], cnt, expect_wait(VEC[v][1:0]));
            cs_n = 4'b1111;
            tick();
        end

        // R5: hold after release of the select
        measure(4'b1110, cnt);
        cs_n = 4'b1111;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R5", int'(ready), 1);
        end

        // R1: a new strobe drops ready
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
        check("R1", int'(ready), 0);

        // R9: select present only on the strobe edge
        cs_n = 4'b1110;
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
        cs_n = 4'b1111;
        repeat (10) tick();
        check("R9", int'(ready), 0);

        // R6: long stall with no select
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
        repeat (60) tick();
        check("R6", int'(ready), 0);

        // R8: reset while a B request is in flight
        cs_n = 4'b1011;
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
        tick();
        tick();
        rst_n = 1'b0;
        cs_n = 4'b1111;
        tick();
        check("R8", int'(ready), 0);
        rst_n = 1'b1;
        repeat (8) tick();
        check("R8", int'(ready), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule